// File: doc/BRIEF.md
# USB Data/Handshake Packet Receive Status Capture

This block sits on a full-speed USB receive path after line decoding. It takes the decoded serial bit stream, including the stuff bits, together with start-of-packet and end-of-packet markers. From these it works out, for each data or handshake packet, four results: a CRC16 failure, a bit-stuffing violation, a malformed length, and whether the packet ID equals a programmable compare byte. The four results are stored together in one 8-bit status byte. That byte changes only at the end of a qualifying packet, so firmware reads a stable picture of the last data or handshake packet between packets.

Inside the block, stuff bits are removed: a zero is expected after six ones and is dropped. The bits that remain are counted. The first eight bits are the packet ID, received least significant bit first. The rest feed a serial CRC16 with polynomial x^16+x^15+x^2+1, preset to all ones. A data packet is good when the residual equals 0x800D. The CPU may overwrite the status byte one bit at a time or as a whole byte, and a hardware update in the same cycle wins.

Top module: `usb_rx_status`

## Requirements
- R1: After the asynchronous reset `rst_ni` is asserted, `status_o` reads 0x00.
- R2: `status_o` is loaded only on a clock edge where `eop_i` ends an open packet of at least 8 destuffed bits whose packet ID has bits [1:0] = 2'b11 (data) or 2'b10 (handshake). Token packets (2'b01), special packets (2'b00) and shorter packets leave the value unchanged. Between such events the value holds unless the CPU writes.
- R3: Bit 7 is 1 when a data packet's CRC16 residual, taken over all destuffed bits after the packet ID, differs from 0x800D. It is always 0 for a handshake packet.
- R4: Bit 6 is 1 when a 1 arrives in the stuff slot, that is, right after six consecutive ones within the packet. Every stuff-slot bit is discarded, and the run count restarts after it.
- R5: Bit 5 is 1 when the destuffed bit count is not a multiple of 8, or when a data packet has fewer than 24 bits.
- R6: Bit 1 is 1 when the 8-bit packet ID equals `pid_cmp_i` at end-of-packet, and 0 otherwise.
- R7: Bits 4, 3, 2 and 0 always read 0, whatever the CPU writes.
- R8: A CPU write with `cpu_byte_i`=1 loads bits 7, 6, 5 and 1 from `cpu_wdata_i`.
- R9: A CPU write with `cpu_byte_i`=0 sets bit `cpu_bit_sel_i` to `cpu_wdata_i[0]` and leaves all other bits unchanged.
- R10: When a status load of R2 and a CPU write fall in the same cycle, only the hardware result is stored.
- R11: Bits are accepted only after a `sop_i` cycle and before `eop_i`. Bits in the `sop_i` or `eop_i` cycle, and bits outside a packet, are ignored. A new `sop_i` restarts all packet analysis.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| sop_i | input | 1 | Start-of-packet marker |
| eop_i | input | 1 | End-of-packet marker |
| bit_valid_i | input | 1 | Strobe for bit_i |
| bit_i | input | 1 | Decoded serial bit, stuff bits included |
| pid_cmp_i | input | 8 | Packet ID compare value |
| cpu_we_i | input | 1 | CPU write strobe |
| cpu_byte_i | input | 1 | 1 = whole-byte write, 0 = single-bit write |
| cpu_bit_sel_i | input | 3 | Bit index for a single-bit write |
| cpu_wdata_i | input | 8 | CPU write data (bit 0 used for a single-bit write) |
| status_o | output | 8 | Status byte |

## Verification
The hardest situation to reach from the ports is the stuff slot itself. The bench has to build a wire stream that inserts a zero after every six ones in a payload containing 0xFF bytes and still carries a valid CRC. It must then inject a raw run of seven ones, which breaks both the stuffing rule and the byte alignment. A reference model destuffs each wire stream independently, works out the expected status byte, and compares it on every clock. A CPU write is also placed in the exact end-of-packet cycle to check the priority rule.

// File: rtl/usb_rx_pkg.sv
package usb_rx_pkg;
  localparam int ST_CRC   = 7;
  localparam int ST_STUFF = 6;
  localparam int ST_LEN   = 5;
  localparam int ST_PID   = 1;
  localparam logic [7:0]  ST_MASK    = 8'hE2;
  localparam logic [15:0] CRC_POLY   = 16'h8005;
  localparam logic [15:0] CRC_INIT   = 16'hFFFF;
  localparam logic [15:0] CRC_RESID  = 16'h800D;
  localparam int          PID_BITS   = 8;
  localparam int          DATA_MIN   = 24;

  typedef enum logic [1:0] {
    PK_SPECIAL = 2'b00,
    PK_TOKEN   = 2'b01,
    PK_HSHK    = 2'b10,
    PK_DATA    = 2'b11
  } pid_kind_e;

  function automatic logic [15:0] crc16_step(logic [15:0] c, logic b);
    logic fb;
    fb = b ^ c[15];
    return {c[14:0], 1'b0} ^ (fb ? CRC_POLY : 16'h0000);
  endfunction
endpackage

// File: rtl/usb_rx_destuff.sv
module usb_rx_destuff #(
  parameter int RUN_MAX = 6
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic start_i,
  input  logic valid_i,
  input  logic bit_i,
  output logic dv_o,
  output logic stuff_err_o
);
  localparam int RW = $clog2(RUN_MAX + 1);

  logic [RW-1:0] run_q;
  logic          slot;

  assign slot = (run_q == RW'(RUN_MAX));
  assign dv_o = valid_i & ~slot;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      run_q       <= '0;
      stuff_err_o <= 1'b0;
    end else if (start_i) begin
      run_q       <= '0;
      stuff_err_o <= 1'b0;
    end else if (valid_i) begin
      if (slot) begin
        run_q <= '0;
        if (bit_i) stuff_err_o <= 1'b1;
      end else begin
        run_q <= bit_i ? run_q + 1'b1 : '0;
      end
    end
  end
endmodule

// File: rtl/usb_rx_track.sv
module usb_rx_track
  import usb_rx_pkg::*;
#(
  parameter int CNT_W = 14
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             start_i,
  input  logic             dv_i,
  input  logic             bit_i,
  output logic [CNT_W-1:0] cnt_o,
  output logic [7:0]       pid_o,
  output logic             pid_done_o
);
  assign pid_done_o = (cnt_o >= CNT_W'(PID_BITS));

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cnt_o <= '0;
      pid_o <= '0;
    end else if (start_i) begin
      cnt_o <= '0;
      pid_o <= '0;
    end else if (dv_i) begin
      if (cnt_o != '1) cnt_o <= cnt_o + 1'b1;
      if (!pid_done_o) pid_o[cnt_o[2:0]] <= bit_i;
    end
  end
endmodule

// File: rtl/usb_rx_crc16.sv
module usb_rx_crc16
  import usb_rx_pkg::*;
(
  input  logic clk_i,
  input  logic rst_ni,
  input  logic start_i,
  input  logic en_i,
  input  logic bit_i,
  output logic good_o
);
  logic [15:0] crc_q;

  assign good_o = (crc_q == CRC_RESID);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)      crc_q <= CRC_INIT;
    else if (start_i) crc_q <= CRC_INIT;
    else if (en_i)    crc_q <= crc16_step(crc_q, bit_i);
  end
endmodule

// File: rtl/usb_rx_status.sv
module usb_rx_status
  import usb_rx_pkg::*;
#(
  parameter int CNT_W   = 14,
  parameter int RUN_MAX = 6
) (
  input  logic       clk_i,
  input  logic       rst_ni,
  input  logic       sop_i,
  input  logic       eop_i,
  input  logic       bit_valid_i,
  input  logic       bit_i,
  input  logic [7:0] pid_cmp_i,
  input  logic       cpu_we_i,
  input  logic       cpu_byte_i,
  input  logic [2:0] cpu_bit_sel_i,
  input  logic [7:0] cpu_wdata_i,
  output logic [7:0] status_o
);
  logic             in_pkt_q;
  logic             accept;
  logic             dv;
  logic             stuff_err;
  logic [CNT_W-1:0] cnt;
  logic [7:0]       pid_q;
  logic             pid_done;
  logic             crc_good;
  pid_kind_e        kind;
  logic             is_data;
  logic             hw_upd;
  logic [7:0]       hw_val;
  logic [7:0]       cpu_val;

  assign accept = in_pkt_q & bit_valid_i & ~sop_i & ~eop_i;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)    in_pkt_q <= 1'b0;
    else if (sop_i) in_pkt_q <= 1'b1;
    else if (eop_i) in_pkt_q <= 1'b0;
  end

  usb_rx_destuff #(.RUN_MAX(RUN_MAX)) u_destuff (
    .clk_i, .rst_ni, .start_i(sop_i), .valid_i(accept), .bit_i,
    .dv_o(dv), .stuff_err_o(stuff_err)
  );

  usb_rx_track #(.CNT_W(CNT_W)) u_track (
    .clk_i, .rst_ni, .start_i(sop_i), .dv_i(dv), .bit_i,
    .cnt_o(cnt), .pid_o(pid_q), .pid_done_o(pid_done)
  );

  usb_rx_crc16 u_crc (
    .clk_i, .rst_ni, .start_i(sop_i), .en_i(dv & pid_done), .bit_i,
    .good_o(crc_good)
  );

  assign kind    = pid_kind_e'(pid_q[1:0]);
  assign is_data = (kind == PK_DATA);
  assign hw_upd  = eop_i & in_pkt_q & pid_done & (kind == PK_DATA || kind == PK_HSHK);

  always_comb begin
    hw_val           = '0;
    hw_val[ST_CRC]   = is_data & ~crc_good;
    hw_val[ST_STUFF] = stuff_err;
    hw_val[ST_LEN]   = (cnt[2:0] != 3'd0) | (is_data & (cnt < CNT_W'(DATA_MIN)));
    hw_val[ST_PID]   = (pid_q == pid_cmp_i);
  end

  always_comb begin
    cpu_val = status_o;
    if (cpu_byte_i) cpu_val = cpu_wdata_i;
    else            cpu_val[cpu_bit_sel_i] = cpu_wdata_i[0];
    cpu_val = cpu_val & ST_MASK;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)       status_o <= '0;
    else if (hw_upd)   status_o <= hw_val;
    else if (cpu_we_i) status_o <= cpu_val;
  end
endmodule

// File: rtl/usb_rx_status_chk.sv
module usb_rx_status_chk (
  input logic       clk_i,
  input logic       rst_ni,
  input logic       eop_i,
  input logic       cpu_we_i,
  input logic       cpu_byte_i,
  input logic [7:0] cpu_wdata_i,
  input logic [7:0] pid_cmp_i,
  input logic [7:0] status_o,
  input logic       hw_upd_i,
  input logic       stuff_err_i,
  input logic [7:0] pid_i
);
  AST_RSV_ZERO: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (status_o & 8'h1D) == 8'h00); // R7

  AST_HOLD_IDLE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!eop_i && !cpu_we_i) |=> $stable(status_o)); // R2

  AST_HS_NO_CRC: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (hw_upd_i && pid_i[1:0] == 2'b10) |=> !status_o[7]); // R3

  AST_STUFF_FLAG: assert property (@(posedge clk_i) disable iff (!rst_ni)
    hw_upd_i |=> status_o[6] == $past(stuff_err_i)); // R4

  AST_PID_MATCH: assert property (@(posedge clk_i) disable iff (!rst_ni)
    hw_upd_i |=> status_o[1] == $past(pid_i == pid_cmp_i)); // R6

  AST_CPU_BYTE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (cpu_we_i && cpu_byte_i && !hw_upd_i) |=> status_o == ($past(cpu_wdata_i) & 8'hE2)); // R8
endmodule

bind usb_rx_status usb_rx_status_chk u_chk (
  .clk_i(clk_i), .rst_ni(rst_ni), .eop_i(eop_i), .cpu_we_i(cpu_we_i),
  .cpu_byte_i(cpu_byte_i), .cpu_wdata_i(cpu_wdata_i), .pid_cmp_i(pid_cmp_i),
  .status_o(status_o), .hw_upd_i(hw_upd), .stuff_err_i(stuff_err), .pid_i(pid_q)
);

// File: tb/usb_rx_status_tb.sv
module usb_rx_status_tb;
  logic       clk_i = 1'b0;
  logic       rst_ni = 1'b0;
  logic       sop_i = 0, eop_i = 0, bit_valid_i = 0, bit_i = 0;
  logic [7:0] pid_cmp_i = 8'h00;
  logic       cpu_we_i = 0, cpu_byte_i = 0;
  logic [2:0] cpu_bit_sel_i = 0;
  logic [7:0] cpu_wdata_i = 0;
  logic [7:0] status_o;

  int checks = 0, fails = 0;
  logic [7:0] exp_st = 8'h00;
  bit done = 0;

  usb_rx_status u_dut (.*);

  always #2 clk_i = ~clk_i;

  task automatic check(string tag, logic [7:0] act, logic [7:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s act=%02h exp=%02h", tag, act, exp);
    end
  endtask

  always @(negedge clk_i) if (rst_ni && !done) check("R2 per-cycle", status_o, exp_st);

  task automatic tick(); @(posedge clk_i); #1; endtask

  // logical bits, LSB first per byte
  function automatic void push_byte(ref bit q[$], input logic [7:0] b);
    for (int i = 0; i < 8; i++) q.push_back(b[i]);
  endfunction

  function automatic void push_crc(ref bit q[$], input int from);
    logic [15:0] c = 16'hFFFF;
    logic fb;
    for (int i = from; i < q.size(); i++) begin
      fb = q[i] ^ c[15];
      c = {c[14:0], 1'b0} ^ (fb ? 16'h8005 : 16'h0);
    end
    for (int i = 15; i >= 0; i--) q.push_back(~c[i]);
  endfunction

  function automatic void stuff(input bit l[$], ref bit w[$]);
    int run = 0;
    foreach (l[i]) begin
      w.push_back(l[i]);
      run = l[i] ? run + 1 : 0;
      if (run == 6) begin w.push_back(1'b0); run = 0; end
    end
  endfunction

  // reference model: -1 means no update
  function automatic int model(input bit w[$], input logic [7:0] cmp);
    bit d[$];
    int run = 0;
    bit serr = 0, data, lerr, cerr;
    logic [7:0] pid, r;
    logic [15:0] c = 16'hFFFF;
    logic fb;
    foreach (w[i]) begin
      if (run == 6) begin if (w[i]) serr = 1; run = 0; end
      else begin d.push_back(w[i]); run = w[i] ? run + 1 : 0; end
    end
    if (d.size() < 8) return -1;
    for (int i = 0; i < 8; i++) pid[i] = d[i];
    if (pid[1] != 1'b1) return -1;
    data = pid[0];
    for (int i = 8; i < d.size(); i++) begin
      fb = d[i] ^ c[15];
      c = {c[14:0], 1'b0} ^ (fb ? 16'h8005 : 16'h0);
    end
    lerr = (d.size() % 8 != 0) || (data && d.size() < 24);
    cerr = data && (c != 16'h800D);
    r = 8'h00;
    r[7] = cerr; r[6] = serr; r[5] = lerr; r[1] = (pid == cmp);
    return int'(r);
  endfunction

  function automatic logic [7:0] cpu_apply(logic [7:0] s, bit byt, logic [2:0] sel, logic [7:0] wd);
    if (byt) s = wd; else s[sel] = wd[0];
    return s & 8'hE2;
  endfunction

  task automatic cpu_write(bit byt, logic [2:0] sel, logic [7:0] wd);
    cpu_we_i = 1; cpu_byte_i = byt; cpu_bit_sel_i = sel; cpu_wdata_i = wd;
    tick();
    cpu_we_i = 0;
    exp_st = cpu_apply(exp_st, byt, sel, wd);
  endtask

  task automatic send(input bit w[$], input bit cpu_at_eop, input logic [7:0] cpu_wd);
    int r;
    sop_i = 1; tick(); sop_i = 0;
    foreach (w[i]) begin bit_valid_i = 1; bit_i = w[i]; tick(); end
    bit_valid_i = 0;
    eop_i = 1;
    if (cpu_at_eop) begin cpu_we_i = 1; cpu_byte_i = 1; cpu_wdata_i = cpu_wd; end
    tick();
    eop_i = 0; cpu_we_i = 0;
    r = model(w, pid_cmp_i);
    if (r >= 0) exp_st = r[7:0];
    else if (cpu_at_eop) exp_st = cpu_apply(exp_st, 1, 0, cpu_wd);
    tick();
  endtask

  task automatic hs(input logic [7:0] pid, input int extra);
    bit l[$], w[$];
    push_byte(l, pid);
    for (int i = 0; i < extra; i++) l.push_back(1'b0);
    stuff(l, w);
    send(w, 0, 0);
  endtask

  initial begin
    bit l[$], w[$];
    #7 rst_ni = 1;
    tick();
    check("R1 reset", status_o, 8'h00);

    pid_cmp_i = 8'hD2; hs(8'hD2, 0);
    check("R6 match", status_o, 8'h02);
    pid_cmp_i = 8'hC3; hs(8'hD2, 0);
    check("R6 mismatch", status_o, 8'h00);

    // R3/R4: good data with FF bytes (stuffing) and valid CRC
    l = {}; w = {};
    push_byte(l, 8'hC3); push_byte(l, 8'hFF); push_byte(l, 8'hFF); push_byte(l, 8'h5A);
    push_crc(l, 8); stuff(l, w); send(w, 0, 0);
    check("R3 good crc", status_o, 8'h02);

    // R3: corrupt a data bit
    l = {}; w = {};
    push_byte(l, 8'h4B); push_byte(l, 8'h12); push_byte(l, 8'h34);
    push_crc(l, 8); l[10] = ~l[10]; stuff(l, w); send(w, 0, 0);
    check("R3 crc error", status_o, 8'h80);

    // R4: seven raw ones after handshake PID
    l = {}; w = {};
    push_byte(l, 8'hD2); stuff(l, w);
    for (int i = 0; i < 7; i++) w.push_back(1'b1);
    send(w, 0, 0);
    check("R4 stuff error", status_o, 8'h60);

    hs(8'hD2, 3);
    check("R5 odd length", status_o, 8'h20);

    // R5: short data packet (PID + 1 byte)
    l = {}; w = {};
    push_byte(l, 8'hC3); push_byte(l, 8'h00); stuff(l, w); send(w, 0, 0);
    check("R5 short data", status_o, 8'hA2);

    // R5 boundary: empty data payload with CRC, exactly 24 bits
    l = {}; w = {};
    push_byte(l, 8'hC3); push_crc(l, 8); stuff(l, w); send(w, 0, 0);
    check("R5 min data ok", status_o, 8'h02);

    // R2: token packet leaves status unchanged
    cpu_write(1, 0, 8'hA0);
    hs(8'hE1, 16);
    check("R2 token ignored", status_o, 8'hA0);

    // R11: bits outside a packet
    for (int i = 0; i < 10; i++) begin bit_valid_i = 1; bit_i = 1; tick(); end
    bit_valid_i = 0; tick();
    check("R11 idle bits", status_o, 8'hA0);

    // R11: sop restart discards junk
    sop_i = 1; tick(); sop_i = 0;
    for (int i = 0; i < 5; i++) begin bit_valid_i = 1; bit_i = 1; tick(); end
    bit_valid_i = 0;
    pid_cmp_i = 8'hD2; hs(8'hD2, 0);
    check("R11 restart", status_o, 8'h02);

    cpu_write(1, 0, 8'hFF);
    check("R8 byte write / R7 reserved", status_o, 8'hE2);
    cpu_write(0, 3'd6, 8'h00);
    check("R9 bit clear", status_o, 8'hA2);
    cpu_write(0, 3'd3, 8'h01);
    check("R7 reserved bit write", status_o, 8'hA2);
    cpu_write(0, 3'd1, 8'h00);
    check("R9 bit1 clear", status_o, 8'hA0);

    // R10: CPU write in the EOP cycle loses
    l = {}; w = {};
    push_byte(l, 8'hD2); stuff(l, w); send(w, 1, 8'hE0);
    check("R10 hw priority", status_o, 8'h02);

    done = 1;
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end

  initial begin
    repeat (50000) @(posedge clk_i);
    done = 1;
    checks++; fails++;
    $display("FAIL watchdog act=timeout exp=done");
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end
endmodule